// File: doc/BRIEF.md
# Scoreboard Issue Stage

This block is the issue stage of a small in-order processor that evaluates finite-field point formulas. Each instruction carries an opcode, one destination register address and two source register addresses. The stage keeps one busy bit per result register. Each cycle it decides whether the instruction at its head can go to the execution unit, or whether that instruction must wait.

Completion notices from the execution unit are absorbed before the decision is made, so a result that completes in a cycle can release a dependent instruction in that same cycle. When the head instruction has a hazard, it is moved into a single parking slot. No further instruction is taken from fetch until the parked one has issued, so program order is always preserved. Fetch, issue and completion each use a valid/ready handshake. Completions are always accepted.

Top module: `issue_stage`

## Requirements
- R1: After a synchronous active-low reset, every busy bit is clear and nothing is parked. With no fetch activity, `iss_valid` is 0 and `fetch_ready` is 1. An instruction naming any addresses then issues at once.
- R2: With nothing parked and `iss_ready` high, a fetched instruction whose three addresses are all free appears on the issue port in the same cycle. The issue port carries the same opcode, destination, source A and source B as the fetched instruction, and the fetch handshake completes in that cycle.
- R3: An instruction is held back when its destination, source A or source B is marked busy. With nothing parked, such an instruction is accepted from fetch (`fetch_ready` 1) into the parking slot and is not issued. From the next cycle on, `fetch_ready` stays 0 while it remains parked.
- R4: A completion (`cmp_valid` with `cmp_addr`) clears the busy bit of that address. A parked instruction issues in the same cycle as the completion that removes its last hazard.
- R5: Issuing an instruction marks its destination busy from the next cycle until a completion names that address. A later instruction that uses that address, as a source or as its destination, waits.
- R6: When a completion and an issue fall in the same cycle, the clear applies before that cycle's hazard check. If both name the same address, the address is busy again from the next cycle, because the new set wins.
- R7: Instructions leave the issue port strictly in the order in which fetch offered them. An instruction waiting behind a parked one is neither issued nor accepted until the parked one has left.
- R8: While `iss_valid` is 1 and `iss_ready` is 0, `fetch_ready` is 0 and the issue port holds the same instruction. No busy bit is set until the handshake completes.
- R9: `cmp_ready` is always 1, so completions are never back-pressured.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| fetch_valid | input | 1 | Fetch offers an instruction |
| fetch_ready | output | 1 | Stage takes the offered instruction this cycle |
| fetch_opc | input | OPC_W | Offered opcode |
| fetch_dst | input | ADDR_W | Offered destination address |
| fetch_srca | input | ADDR_W | Offered first source address |
| fetch_srcb | input | ADDR_W | Offered second source address |
| iss_valid | output | 1 | An instruction is issued toward execution |
| iss_ready | input | 1 | Execution unit accepts the issued instruction |
| iss_opc | output | OPC_W | Issued opcode |
| iss_dst | output | ADDR_W | Issued destination address |
| iss_srca | output | ADDR_W | Issued first source address |
| iss_srcb | output | ADDR_W | Issued second source address |
| cmp_valid | input | 1 | A result has completed |
| cmp_ready | output | 1 | Completion accepted (constant 1) |
| cmp_addr | input | ADDR_W | Address of the completed result |

## Verification
Completion and issue can happen in the same cycle. The bench provokes this by raising `cmp_valid` in the cycle where a parked or freshly fetched instruction waits on that same address. It also raises `cmp_valid` together with a fresh instruction whose destination is the completing address. The judgement has two parts. The issue must occur in that very cycle, which shows the clear came first. A follow-up instruction that reads the address must then park, which shows the set came last. A reference busy map in the bench, updated from the handshakes, confirms that no issued instruction named an address still marked busy.

// File: rtl/issue_pkg.sv
// Shared defaults for the issue stage: field widths and the
// encoding of where the head instruction currently comes from.
package issue_pkg;
    localparam int DEF_OPC_W  = 4;
    localparam int DEF_ADDR_W = 5;
    localparam int NUM_OPS    = 3;   // destination, source A, source B

    typedef enum logic [1:0] {
        HEAD_NONE  = 2'd0,
        HEAD_FETCH = 2'd1,
        HEAD_PARK  = 2'd2
    } head_src_e;
endpackage

// File: rtl/issue_busy_table.sv
// Per-address busy bits over the result register space.
// Assumes at most one clear and one set per cycle. The clear is
// visible combinationally in busy_eff (the view used for the
// hazard check); at the clock edge the set is applied after the
// clear, so it wins on the same address.
module issue_busy_table #(
    parameter int ADDR_W = 5,
    localparam int DEPTH = 1 << ADDR_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr_en,
    input  logic [ADDR_W-1:0] clr_addr,
    input  logic              set_en,
    input  logic [ADDR_W-1:0] set_addr,
    output logic [DEPTH-1:0]  busy_eff
);
    logic [DEPTH-1:0] busy_q;
    logic [DEPTH-1:0] clr_vec;
    logic [DEPTH-1:0] set_vec;

    // Decode the clear and set addresses into one-hot masks.
    always_comb begin
        clr_vec = '0;
        set_vec = '0;
        if (clr_en) clr_vec[clr_addr] = 1'b1;
        if (set_en) set_vec[set_addr] = 1'b1;
    end

    assign busy_eff = busy_q & ~clr_vec;

    // Register the table: the clear first, then the set on top.
    always_ff @(posedge clk) begin
        if (!rst_n) busy_q <= '0;
        else        busy_q <= busy_eff | set_vec;
    end

    assert_reset_clear_R1: assert property (@(posedge clk)
        !rst_n |=> (busy_q == '0));

    assert_set_marks_R5: assert property (@(posedge clk) disable iff (!rst_n)
        set_en |=> busy_q[$past(set_addr)]);

    assert_clear_frees_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_en && !(set_en && set_addr == clr_addr)) |=> !busy_q[$past(clr_addr)]);

    assert_set_wins_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_en && set_en && set_addr == clr_addr) |=> busy_q[$past(clr_addr)]);
endmodule

// File: rtl/issue_hazard_check.sv
// Combinational hazard test: an instruction is free only when
// none of its operand addresses is marked busy in the given map.
// Assumes the map already reflects completions of this cycle.
module issue_hazard_check #(
    parameter int ADDR_W  = 5,
    parameter int NUM_OPS = 3,
    localparam int DEPTH  = 1 << ADDR_W
) (
    input  logic [DEPTH-1:0]          busy,
    input  logic [NUM_OPS*ADDR_W-1:0] addrs,
    output logic                      free
);
    logic [NUM_OPS-1:0] hit;

    // One lookup per operand address.
    for (genvar g = 0; g < NUM_OPS; g++) begin : g_op
        assign hit[g] = busy[addrs[g*ADDR_W +: ADDR_W]];
    end

    assign free = ~|hit;
endmodule

// File: rtl/issue_park_slot.sv
// Single-entry holding register for an instruction that could not
// issue. Assumes the owner never loads while the slot is full.
module issue_park_slot #(
    parameter int W = 19
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_data,
    input  logic         drop,
    output logic         valid_q,
    output logic [W-1:0] data_q
);
    // Track occupancy of the slot.
    always_ff @(posedge clk) begin
        if (!rst_n)    valid_q <= 1'b0;
        else if (load) valid_q <= 1'b1;
        else if (drop) valid_q <= 1'b0;
    end

    // Capture the instruction word when parking.
    always_ff @(posedge clk) begin
        if (!rst_n)    data_q <= '0;
        else if (load) data_q <= load_data;
    end

    assert_single_entry_R7: assert property (@(posedge clk) disable iff (!rst_n)
        load |-> !valid_q);

    assert_park_holds_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_q && !drop) |=> (valid_q && $stable(data_q)));
endmodule

// File: rtl/issue_stage.sv
// In-order issue stage with a busy-bit table and one parking slot.
// The head instruction is the parked one if any, otherwise the one
// offered by fetch. It issues when it is hazard-free after this
// cycle's completion is absorbed; a hazardous fetch is parked.
// Assumes fetch and the execution unit obey valid/ready.
module issue_stage
    import issue_pkg::*;
#(
    parameter int OPC_W  = DEF_OPC_W,
    parameter int ADDR_W = DEF_ADDR_W,
    localparam int WORD_W = OPC_W + NUM_OPS * ADDR_W,
    localparam int DEPTH  = 1 << ADDR_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fetch_valid,
    output logic              fetch_ready,
    input  logic [OPC_W-1:0]  fetch_opc,
    input  logic [ADDR_W-1:0] fetch_dst,
    input  logic [ADDR_W-1:0] fetch_srca,
    input  logic [ADDR_W-1:0] fetch_srcb,
    output logic              iss_valid,
    input  logic              iss_ready,
    output logic [OPC_W-1:0]  iss_opc,
    output logic [ADDR_W-1:0] iss_dst,
    output logic [ADDR_W-1:0] iss_srca,
    output logic [ADDR_W-1:0] iss_srcb,
    input  logic              cmp_valid,
    output logic              cmp_ready,
    input  logic [ADDR_W-1:0] cmp_addr
);
    logic [WORD_W-1:0] fetch_word;
    logic [WORD_W-1:0] park_word;
    logic [WORD_W-1:0] head_word;
    logic              park_valid;
    logic              head_free;
    logic              iss_fire;
    logic              fetch_fire;
    logic [DEPTH-1:0]  busy_eff;
    head_src_e         head_src;

    assign fetch_word = {fetch_opc, fetch_dst, fetch_srca, fetch_srcb};
    assign cmp_ready  = 1'b1;

    // Select the head instruction: parked first, else fetch.
    always_comb begin
        if (park_valid)       head_src = HEAD_PARK;
        else if (fetch_valid) head_src = HEAD_FETCH;
        else                  head_src = HEAD_NONE;
        head_word = (head_src == HEAD_PARK) ? park_word : fetch_word;
    end

    assign {iss_opc, iss_dst, iss_srca, iss_srcb} = head_word;
    assign iss_valid   = (head_src != HEAD_NONE) && head_free;
    assign iss_fire    = iss_valid && iss_ready;
    assign fetch_ready = !park_valid && iss_ready;
    assign fetch_fire  = fetch_valid && fetch_ready;

    issue_busy_table #(.ADDR_W(ADDR_W)) u_busy (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr_en   (cmp_valid),
        .clr_addr (cmp_addr),
        .set_en   (iss_fire),
        .set_addr (iss_dst),
        .busy_eff (busy_eff)
    );

    issue_hazard_check #(.ADDR_W(ADDR_W), .NUM_OPS(NUM_OPS)) u_hazard (
        .busy  (busy_eff),
        .addrs (head_word[NUM_OPS*ADDR_W-1:0]),
        .free  (head_free)
    );

    issue_park_slot #(.W(WORD_W)) u_park (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (fetch_fire && !head_free),
        .load_data (fetch_word),
        .drop      (park_valid && iss_fire),
        .valid_q   (park_valid),
        .data_q    (park_word)
    );

    assert_blocked_holds_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (iss_valid && !iss_ready) |=> (iss_valid && $stable(head_word)));

    assert_parked_blocks_fetch_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (fetch_fire && !iss_fire) |=> !fetch_ready);

    assert_cmp_always_ready_R9: assert property (@(posedge clk) disable iff (!rst_n)
        cmp_ready);
endmodule

// File: tb/issue_stage_tb_top.sv
// Scoreboard bench: the driver queues each offered instruction; a
// monitor pops and compares on every issue handshake and checks the
// operands against a reference busy map kept from the handshakes.
module issue_stage_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int OPC_W  = 4;
    localparam int ADDR_W = 5;
    localparam int WORD_W = OPC_W + 3 * ADDR_W;
    localparam int DEPTH  = 1 << ADDR_W;

    logic clk = 1'b0;
    logic rst_n;
    logic fetch_valid, fetch_ready;
    logic [OPC_W-1:0]  fetch_opc;
    logic [ADDR_W-1:0] fetch_dst, fetch_srca, fetch_srcb;
    logic iss_valid, iss_ready;
    logic [OPC_W-1:0]  iss_opc;
    logic [ADDR_W-1:0] iss_dst, iss_srca, iss_srcb;
    logic cmp_valid, cmp_ready;
    logic [ADDR_W-1:0] cmp_addr;

    int errors = 0;
    int checks = 0;
    logic [WORD_W-1:0] expq[$];
    logic [DEPTH-1:0]  ref_busy = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    issue_stage #(.OPC_W(OPC_W), .ADDR_W(ADDR_W)) dut_i (
        .clk(clk), .rst_n(rst_n),
        .fetch_valid(fetch_valid), .fetch_ready(fetch_ready),
        .fetch_opc(fetch_opc), .fetch_dst(fetch_dst),
        .fetch_srca(fetch_srca), .fetch_srcb(fetch_srcb),
        .iss_valid(iss_valid), .iss_ready(iss_ready),
        .iss_opc(iss_opc), .iss_dst(iss_dst),
        .iss_srca(iss_srca), .iss_srcb(iss_srcb),
        .cmp_valid(cmp_valid), .cmp_ready(cmp_ready), .cmp_addr(cmp_addr)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk); #1;
    endtask

    task automatic at_neg();
        @(negedge clk);
    endtask

    task automatic put(input int o, input int d, input int a, input int b);
        fetch_valid = 1'b1;
        fetch_opc = OPC_W'(o); fetch_dst = ADDR_W'(d);
        fetch_srca = ADDR_W'(a); fetch_srcb = ADDR_W'(b);
        expq.push_back({OPC_W'(o), ADDR_W'(d), ADDR_W'(a), ADDR_W'(b)});
    endtask

    task automatic idle();
        fetch_valid = 1'b0;
    endtask

    task automatic cmp_on(input int addr);
        cmp_valid = 1'b1; cmp_addr = ADDR_W'(addr);
    endtask

    // Monitor: compare each issued instruction and update the busy map.
    always @(negedge clk) begin
        if (rst_n) begin
            logic [DEPTH-1:0] eff;
            eff = ref_busy;
            if (cmp_valid) eff[cmp_addr] = 1'b0;
            if (iss_valid && iss_ready) begin
                logic [WORD_W-1:0] got;
                got = {iss_opc, iss_dst, iss_srca, iss_srcb};
                if (expq.size() == 0) begin
                    chk("R7 unexpected issue", int'(got), -1);
                end else begin
                    chk("R7 issue order", int'(got), int'(expq.pop_front()));
                end
                chk("R3 no busy operand at issue",
                    int'({eff[iss_dst], eff[iss_srca], eff[iss_srcb]}), 0);
                eff[iss_dst] = 1'b1;
            end
            ref_busy = eff;
        end
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        rst_n = 1'b0; fetch_valid = 1'b0; fetch_opc = '0; fetch_dst = '0;
        fetch_srca = '0; fetch_srcb = '0; iss_ready = 1'b1;
        cmp_valid = 1'b0; cmp_addr = '0;
        repeat (3) step();
        rst_n = 1'b1;
        at_neg();
        chk("R1 fetch_ready after reset", int'(fetch_ready), 1);
        chk("R1 iss_valid after reset", int'(iss_valid), 0);
        chk("R9 cmp_ready", int'(cmp_ready), 1);
        step();

        // I1: hazard-free, issues in the cycle it is offered.
        put(1, 3, 1, 2);
        at_neg();
        chk("R2 immediate issue", int'(iss_valid), 1);
        chk("R2 issued dst", int'(iss_dst), 3);
        chk("R1 all clear after reset", int'(fetch_ready), 1);
        step(); idle();

        // I2: reads 3 (busy) -> parked.
        put(2, 4, 3, 0);
        at_neg();
        chk("R3 raw hazard holds", int'(iss_valid), 0);
        chk("R3 hazard accepted into park", int'(fetch_ready), 1);
        step(); idle();
        at_neg();
        chk("R3 fetch blocked while parked", int'(fetch_ready), 0);
        step();

        // I3 waits behind the parked I2.
        put(3, 5, 6, 7);
        at_neg();
        chk("R7 no bypass of parked", int'(iss_valid), 0);
        chk("R7 later fetch not taken", int'(fetch_ready), 0);
        step();

        // Completion of 3 releases I2 in the same cycle.
        cmp_on(3);
        at_neg();
        chk("R4 release on completion", int'(iss_valid), 1);
        chk("R4 parked dst", int'(iss_dst), 4);
        chk("R4 fetch still held", int'(fetch_ready), 0);
        step(); cmp_valid = 1'b0;
        at_neg();
        chk("R7 next in order", int'(iss_dst), 5);
        step(); idle();

        // I4: destination 4 busy (write after write) -> parked.
        put(4, 4, 0, 0);
        at_neg();
        chk("R3 waw hazard holds", int'(iss_valid), 0);
        step(); idle();
        cmp_on(4);
        at_neg();
        chk("R4 waw released", int'(iss_valid), 1);
        step(); cmp_valid = 1'b0;

        // I5 reads 4, which I4 set busy again.
        put(5, 10, 4, 4);
        at_neg();
        chk("R5 dst busy after issue", int'(iss_valid), 0);
        step(); idle();
        cmp_on(4);
        at_neg();
        chk("R5 cleared by completion", int'(iss_valid), 1);
        step(); cmp_valid = 1'b0;

        // I6 writes 5 in the cycle 5 completes: clear first, set last.
        put(6, 5, 1, 1);
        cmp_on(5);
        at_neg();
        chk("R6 clear before check", int'(iss_valid), 1);
        step(); idle(); cmp_valid = 1'b0;
        put(7, 11, 5, 2);
        at_neg();
        chk("R6 set wins same address", int'(iss_valid), 0);
        step(); idle();
        cmp_on(5);
        at_neg();
        chk("R6 released after later completion", int'(iss_valid), 1);
        step(); cmp_valid = 1'b0;

        // Back-pressure from execution.
        iss_ready = 1'b0;
        put(8, 12, 0, 0);
        at_neg();
        chk("R8 valid while blocked", int'(iss_valid), 1);
        chk("R8 fetch blocked", int'(fetch_ready), 0);
        step();
        at_neg();
        chk("R8 valid held", int'(iss_valid), 1);
        chk("R8 dst held", int'(iss_dst), 12);
        chk("R8 fetch still blocked", int'(fetch_ready), 0);
        step();
        iss_ready = 1'b1;
        at_neg();
        chk("R8 issues when ready", int'(iss_valid), 1);
        step(); idle();

        // I9 reads 12, busy since I8 issued.
        put(9, 13, 12, 0);
        at_neg();
        chk("R5 source busy", int'(iss_valid), 0);
        step(); idle();
        cmp_on(12);
        at_neg();
        chk("R4 source released", int'(iss_valid), 1);
        step(); cmp_valid = 1'b0;

        repeat (3) step();
        chk("R7 all instructions issued", expq.size(), 0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule